// File: doc/BRIEF.md
# Tile Configuration Address Decoder

This block is the configuration entry point of one tile in a tiled array. A shared configuration bus brings a 32-bit address, 32-bit write data and separate write and read strobes. The decoder compares the target-tile field of the address with the tile's own identifier, which arrives on an input port and may change while the tile runs. When they agree, it decodes a feature number and a register number. It then forwards a write strobe, the register number and the data to the register bank of that one feature.

On a matching read, the decoder selects the read data of the addressed feature bank and registers it. The value appears on the common read-data output one cycle after the read strobe. In every other cycle that output is zero. Requests for another tile, and requests that name a feature slot with no bank attached, change nothing.

Top module: `cfg_tile_decoder`

## Requirements
- R1: The address is split into fields: bits [15:0] hold the target tile ID, bits [23:16] the feature number and bits [31:24] the register number. The register number is passed to the banks on `bank_reg_sel`, and the write data is passed unchanged on `bank_wdata`.
- R2: A write (`cfg_wr`=1, `cfg_rd`=0) whose tile field equals `tile_id` and whose feature number f is below NUM_FEAT sets bit f of `bank_wr`, and only that bit, in the same cycle.
- R3: A write whose tile field differs from `tile_id` raises no `bank_wr` bit, so every bank keeps its contents.
- R4: A request whose feature number is NUM_FEAT or more raises no `bank_wr` bit. A read of such a feature returns zero.
- R5: A matching read of an address written earlier returns the 32-bit value that was written. It appears on `cfg_rdata` in the cycle after the read strobe.
- R6: `cfg_rdata` is zero in every cycle that does not follow a matching read of an attached feature. This includes reads aimed at another tile and cycles with no request.
- R7: `tile_id` is compared on every request. After it changes, requests carrying the new ID are accepted and requests carrying the old ID are ignored.
- R8: Reset is synchronous and active high. It forces `cfg_rdata` to zero at the next clock edge, even when a read is requested in the same cycle.
- R9: At most one `bank_wr` bit is high in any cycle. None is high without `cfg_wr`, or when `cfg_wr` and `cfg_rd` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_id | input | 16 | This tile's identifier |
| cfg_addr | input | 32 | Configuration address (tile, feature, register) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| bank_wr | output | NUM_FEAT | One-hot write strobe per feature bank |
| bank_reg_sel | output | 8 | Register number for the banks |
| bank_wdata | output | 32 | Write data for the banks |
| bank_rdata | input | 32*NUM_FEAT | Read data of all banks, feature f at bits [32f+31:32f] |
| cfg_rdata | output | 32 | Registered read data |

## Verification
The bench first fills every attached feature with distinct values. It then sends the same addresses with a wrong tile ID, and reads everything back. A decoder that ignored the ID, or compared only part of it, would corrupt those values. The bench names feature slots beyond the last attached bank, where a decoder that truncates the feature number would alias onto bank 0 or 1. It also changes `tile_id` at run time, which catches a decoder that latched the ID at reset. Each read is followed by idle cycles and foreign-tile reads, and a reset is asserted together with a read; these expose an output register that holds stale data or lets reset lose to a read.

// File: rtl/cfg_dec_pkg.sv
package cfg_dec_pkg;

    localparam int DATA_W = 32;
    localparam int ID_W   = 16;
    localparam int FEAT_W = 8;
    localparam int REG_W  = 8;
    localparam int ADDR_W = ID_W + FEAT_W + REG_W;

    // Field order fixed by the bus: register number on top, tile ID at bottom
    typedef struct packed {
        logic [REG_W-1:0]  reg_num;
        logic [FEAT_W-1:0] feat_num;
        logic [ID_W-1:0]   tile;
    } cfg_addr_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_BAD   = 2'b11
    } cfg_op_e;

    function automatic cfg_op_e op_of(input logic wr, input logic rd);
        return cfg_op_e'({rd, wr});
    endfunction

endpackage

// File: rtl/cfg_id_match.sv
module cfg_id_match
    import cfg_dec_pkg::*;
(
    input  logic [ID_W-1:0] own_id,
    input  logic [ID_W-1:0] req_id,
    output logic            hit
);
    assign hit = (own_id == req_id);
endmodule

// File: rtl/cfg_feat_decode.sv
module cfg_feat_decode
    import cfg_dec_pkg::*;
#(
    parameter int NUM_FEAT = 4
) (
    input  logic [FEAT_W-1:0]   feat_num,
    output logic [NUM_FEAT-1:0] sel,
    output logic                attached
);
    for (genvar g = 0; g < NUM_FEAT; g++) begin : g_sel
        assign sel[g] = (feat_num == FEAT_W'(g));
    end
    assign attached = |sel;
endmodule

// File: rtl/cfg_rd_return.sv
module cfg_rd_return
    import cfg_dec_pkg::*;
#(
    parameter int NUM_FEAT = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_go,
    input  logic [NUM_FEAT-1:0]        sel,
    input  logic [DATA_W*NUM_FEAT-1:0] bank_rdata,
    output logic [DATA_W-1:0]          rdata_q
);
    logic [DATA_W-1:0] term [NUM_FEAT];
    logic [DATA_W-1:0] mux_out;

    for (genvar g = 0; g < NUM_FEAT; g++) begin : g_term
        assign term[g] = sel[g] ? bank_rdata[g*DATA_W +: DATA_W] : '0;
    end

    always_comb begin
        mux_out = '0;
        for (int i = 0; i < NUM_FEAT; i++) begin
            mux_out = mux_out | term[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_go) begin
            rdata_q <= mux_out;
        end else begin
            rdata_q <= '0;
        end
    end
endmodule

// File: rtl/cfg_tile_decoder.sv
module cfg_tile_decoder
    import cfg_dec_pkg::*;
#(
    parameter int NUM_FEAT = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ID_W-1:0]            tile_id,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [DATA_W-1:0]          cfg_wdata,
    input  logic                       cfg_wr,
    input  logic                       cfg_rd,
    output logic [NUM_FEAT-1:0]        bank_wr,
    output logic [REG_W-1:0]           bank_reg_sel,
    output logic [DATA_W-1:0]          bank_wdata,
    input  logic [DATA_W*NUM_FEAT-1:0] bank_rdata,
    output logic [DATA_W-1:0]          cfg_rdata
);
    cfg_addr_t             addr_f;
    cfg_op_e               op;
    logic                  id_hit;
    logic                  attached;
    logic [NUM_FEAT-1:0]   sel;
    logic                  rd_go;

    assign addr_f = cfg_addr_t'(cfg_addr);
    assign op     = op_of(cfg_wr, cfg_rd);

    cfg_id_match i_match (
        .own_id (tile_id),
        .req_id (addr_f.tile),
        .hit    (id_hit)
    );

    cfg_feat_decode #(.NUM_FEAT(NUM_FEAT)) i_feat (
        .feat_num (addr_f.feat_num),
        .sel      (sel),
        .attached (attached)
    );

    assign bank_wr      = (op == OP_WRITE && id_hit) ? sel : '0;
    assign bank_reg_sel = addr_f.reg_num;
    assign bank_wdata   = cfg_wdata;
    assign rd_go        = (op == OP_READ) && id_hit && attached;

    cfg_rd_return #(.NUM_FEAT(NUM_FEAT)) i_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_go      (rd_go),
        .sel        (sel),
        .bank_rdata (bank_rdata),
        .rdata_q    (cfg_rdata)
    );
endmodule

// File: rtl/cfg_tile_decoder_chk.sv
module cfg_tile_decoder_chk
    import cfg_dec_pkg::*;
#(
    parameter int NUM_FEAT = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [ID_W-1:0]     tile_id,
    input logic [ADDR_W-1:0]   cfg_addr,
    input logic                cfg_wr,
    input logic                cfg_rd,
    input logic [NUM_FEAT-1:0] bank_wr,
    input logic [DATA_W-1:0]   cfg_rdata
);
    logic id_ok;
    logic in_range;
    assign id_ok    = (cfg_addr[ID_W-1:0] == tile_id);
    assign in_range = (int'(cfg_addr[ID_W +: FEAT_W]) < NUM_FEAT);

    // R9
    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_wr));
    p_nowr_r9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr || cfg_rd) |-> (bank_wr == '0));
    // R3
    p_mismatch_r3: assert property (@(posedge clk) disable iff (rst)
        !id_ok |-> (bank_wr == '0));
    // R4
    p_range_r4: assert property (@(posedge clk) disable iff (rst)
        !in_range |-> (bank_wr == '0));
    // R2
    p_hit_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_rd && id_ok && in_range) |-> ($countones(bank_wr) == 1));
    // R6
    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !(cfg_rd && !cfg_wr && id_ok && in_range) |=> (cfg_rdata == '0));
    // R8
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (cfg_rdata == '0));
endmodule

bind cfg_tile_decoder cfg_tile_decoder_chk #(.NUM_FEAT(NUM_FEAT)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .tile_id   (tile_id),
    .cfg_addr  (cfg_addr),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .bank_wr   (bank_wr),
    .cfg_rdata (cfg_rdata)
);

// File: tb/test_cfg_tile_decoder.sv
module test_cfg_tile_decoder;
    localparam int NF = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [15:0]      tile_id = 16'h0000;
    logic [31:0]      cfg_addr = '0;
    logic [31:0]      cfg_wdata = '0;
    logic             cfg_wr = 1'b0;
    logic             cfg_rd = 1'b0;
    logic [NF-1:0]    bank_wr;
    logic [7:0]       bank_reg_sel;
    logic [31:0]      bank_wdata;
    logic [32*NF-1:0] bank_rdata;
    logic [31:0]      cfg_rdata;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    string tag = "R8";

    // 50 MHz
    always #10 clk = ~clk;

    cfg_tile_decoder #(.NUM_FEAT(NF)) i_cfg_tile_decoder (
        .clk(clk), .rst(rst), .tile_id(tile_id), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .bank_wr(bank_wr), .bank_reg_sel(bank_reg_sel), .bank_wdata(bank_wdata),
        .bank_rdata(bank_rdata), .cfg_rdata(cfg_rdata)
    );

    // Feature banks: plain register files driven only by the decoder's strobes
    logic [31:0] bank [NF][256];
    initial begin
        for (int f = 0; f < NF; f++)
            for (int r = 0; r < 256; r++) bank[f][r] = '0;
    end
    always @(posedge clk) begin
        for (int f = 0; f < NF; f++)
            if (bank_wr[f]) bank[f][bank_reg_sel] <= bank_wdata;
    end
    always_comb begin
        for (int f = 0; f < NF; f++) bank_rdata[f*32 +: 32] = bank[f][bank_reg_sel];
    end

    // Reference model: accepted writes keyed by {feature, register}
    logic [31:0] ref_mem [int];
    logic [31:0] exp_rd = '0;

    function automatic bit accepted(input logic [31:0] a, input logic [15:0] id);
        return (a[15:0] == id) && (int'(a[23:16]) < NF);
    endfunction

    always @(posedge clk) begin
        int key;
        key = int'(cfg_addr[31:16]);
        if (rst) exp_rd <= '0;
        else if (cfg_rd && !cfg_wr && accepted(cfg_addr, tile_id))
            exp_rd <= ref_mem.exists(key) ? ref_mem[key] : 32'h0;
        else exp_rd <= '0;
        if (!rst && cfg_wr && !cfg_rd && accepted(cfg_addr, tile_id))
            ref_mem[key] = cfg_wdata;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Read data compared on every cycle, away from the rising edge
    always @(negedge clk) begin
        if (chk_on) check(tag, cfg_rdata, exp_rd);
    end

    task automatic op(input bit wr, input bit rd, input logic [31:0] a,
                      input logic [31:0] d, input string req);
        logic [NF-1:0] exp_wr;
        @(negedge clk);
        tag = req;
        cfg_wr = wr; cfg_rd = rd; cfg_addr = a; cfg_wdata = d;
        #2;
        exp_wr = '0;
        if (wr && !rd && accepted(a, tile_id)) exp_wr[a[23:16]] = 1'b1;
        check({req, " strobe R2/R9"}, 32'(bank_wr), 32'(exp_wr));
        check("R1 reg field", 32'(bank_reg_sel), 32'(a[31:24]));
        check("R1 wdata", bank_wdata, d);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, 32'h0, 32'h0, req);
    endtask

    function automatic logic [31:0] mk(input int r, input int f, input logic [15:0] id);
        return {r[7:0], f[7:0], id};
    endfunction

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tile_id = 16'hA5C3;
        @(negedge clk); @(negedge clk);
        check("R8 reset value", cfg_rdata, 32'h0);
        rst = 1'b0;
        chk_on = 1'b1;

        // R2: fill banks
        for (int f = 0; f < NF; f++)
            for (int r = 0; r < 3; r++)
                op(1'b1, 1'b0, mk(r * 37, f, tile_id), 32'h1000_0000 * (f + 1) + r * 17 + 1, "R2");
        // R5: read back
        for (int f = 0; f < NF; f++)
            for (int r = 0; r < 3; r++)
                op(1'b0, 1'b1, mk(r * 37, f, tile_id), 32'h0, "R5");
        idle(2, "R6");

        // R3: foreign-tile writes, then read back unchanged
        for (int f = 0; f < NF; f++) begin
            op(1'b1, 1'b0, mk(0, f, tile_id + 16'h1), 32'hDEAD_BEEF, "R3");
            op(1'b1, 1'b0, mk(37, f, tile_id ^ 16'h8000), 32'hFFFF_FFFF, "R3");
        end
        for (int f = 0; f < NF; f++) begin
            op(1'b0, 1'b1, mk(0, f, tile_id), 32'h0, "R3");
            op(1'b0, 1'b1, mk(37, f, tile_id), 32'h0, "R3");
        end

        // R6: foreign-tile read and idle give zero
        op(1'b0, 1'b1, mk(0, 0, tile_id - 16'h1), 32'h0, "R6");
        op(1'b0, 1'b1, mk(0, 1, tile_id), 32'h0, "R6");
        idle(1, "R6");
        // R9: both strobes at once does nothing
        op(1'b1, 1'b1, mk(0, 2, tile_id), 32'h1234_5678, "R9");
        op(1'b0, 1'b1, mk(0, 2, tile_id), 32'h0, "R9");

        // R4: unattached features
        op(1'b1, 1'b0, mk(0, NF, tile_id), 32'hCAFE_0001, "R4");
        op(1'b1, 1'b0, mk(0, NF + 4, tile_id), 32'hCAFE_0002, "R4");
        op(1'b1, 1'b0, mk(0, 255, tile_id), 32'hCAFE_0003, "R4");
        op(1'b0, 1'b1, mk(0, NF, tile_id), 32'h0, "R4");
        op(1'b0, 1'b1, mk(0, 255, tile_id), 32'h0, "R4");
        op(1'b0, 1'b1, mk(0, 0, tile_id), 32'h0, "R4");
        op(1'b0, 1'b1, mk(0, 1, tile_id), 32'h0, "R4");

        // R7: change the ID at run time
        @(negedge clk);
        tile_id = 16'h0042;
        op(1'b1, 1'b0, mk(5, 3, 16'h0042), 32'h7777_0042, "R7");
        op(1'b1, 1'b0, mk(5, 3, 16'hA5C3), 32'h0BAD_0BAD, "R7");
        op(1'b0, 1'b1, mk(5, 3, 16'h0042), 32'h0, "R7");
        op(1'b0, 1'b1, mk(5, 3, 16'hA5C3), 32'h0, "R7");
        op(1'b0, 1'b1, mk(37, 2, 16'h0042), 32'h0, "R7");

        // R8: reset together with a read
        @(negedge clk);
        rst = 1'b1;
        op(1'b0, 1'b1, mk(5, 3, 16'h0042), 32'h0, "R8");
        @(negedge clk);
        rst = 1'b0;
        idle(1, "R8");
        op(1'b0, 1'b1, mk(5, 3, 16'h0042), 32'h0, "R5");
        idle(2, "R6");

        chk_on = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule